// File: doc/BRIEF.md
# SCL Hold Watchdog for an I2C Target

This block runs alongside an I2C target receiver and enforces a maximum SCL high time at a few chosen points of each transfer. After a reference edge on the bus, the controller has a fixed number of system clock cycles to pull SCL low again. If it fails to do so, the watchdog signals the receiver to abandon the transfer, so the controller sees a not-acknowledge.

Four reference edges arm the window. The first is a START condition, where SDA falls while SCL stays high. The second is the SCL rise for bit 8 of an address byte, which is the read/write bit. The third is the SCL rise for bit 8 of a write command byte. The fourth is the SCL rise of the acknowledge slot, which is the ninth bit of any byte. All other bit positions are left to a byte-level timer elsewhere.

The raw bus lines pass through a synchronizer, and all edges are taken from the synchronized copies. The receiver supplies the bit index and the byte-kind flags, and these stay steady while SCL is high. The watchdog reports a violation in two ways: a one-cycle abort pulse and a sticky flag that software clears.

Top module: `scl_hold_watchdog`

## Requirements
- R1: After reset, `abortPulse` and `timeoutSticky` are 0 and no window is armed. An idle bus with both lines high raises no abort.
- R2: A START condition (SDA falls while SCL is steadily high) arms the window. If SCL does not fall within the window, an abort follows.
- R3: An SCL rise while `addrByte`=1 and `bitIdx`=8 (the read/write bit) arms the window.
- R4: An SCL rise while `cmdByte`=1 and `bitIdx`=8 arms the window.
- R5: An SCL rise while `ackSlot`=1 arms the window, whatever the value of `bitIdx`.
- R6: An SCL rise at any other position never arms the window. This covers `bitIdx`≠8 in an address or command byte, and bit 8 when no flag is set. SCL may then stay high for any length of time without an abort.
- R7: Let D be the number of clock cycles between a raw SCL rise and the next raw SCL fall. With `WINDOW_CYCLES`=W, D ≤ W raises no abort and D = W+1 raises one. After synchronization, the abort pulse appears W+1 cycles after the reference edge is detected.
- R8: `abortPulse` is high for exactly one cycle per violation. `timeoutSticky` sets on the cycle after the pulse and stays set until `swClear` is high for a cycle. If both happen in the same cycle, the new abort wins.
- R9: A STOP condition (SDA rises while SCL is steadily high) disarms the window without an abort.
- R10: A new reference edge while a window is armed restarts the count from zero. An example is a repeated START during a high ACK clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclRaw | input | 1 | Unsynchronized SCL line |
| sdaRaw | input | 1 | Unsynchronized SDA line |
| bitIdx | input | BIDX_W | 1-based bit index within the current byte, taken from the receiver |
| addrByte | input | 1 | The current byte is the address byte |
| cmdByte | input | 1 | The current byte is a write command byte |
| ackSlot | input | 1 | The current bit is the acknowledge slot |
| swClear | input | 1 | Clears the sticky timeout flag |
| abortPulse | output | 1 | One-cycle request to drop the transfer |
| timeoutSticky | output | 1 | Latched record of a timeout |

## Verification
A counter that loads late or compares one value off moves the abort pulse by a cycle. The bench catches this in the first cycle of a boundary hold of exactly W or W+1 cycles, because it compares the outputs to a reference model every clock. A wrongly decoded bit position shows up as an extra or missing abort about W cycles after the SCL rise. A window that stays armed after a STOP shows up as a false abort within W cycles. A sticky flag that clears on its own, or a pulse that lasts two cycles, differs from the model on the very next cycle.

// File: rtl/scl_hold_pkg.sv
package scl_hold_pkg;
  // Bus events derived from the synchronized lines
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startCond;
    logic stopCond;
  } lineEvt_t;

  // Strobes from control to the window counter
  typedef struct packed {
    logic arm;
    logic clear;
  } winCmd_t;
endpackage

// File: rtl/scl_hold_dp.sv
module scl_hold_dp
  import scl_hold_pkg::*;
#(
  parameter int WINDOW_CYCLES = 5000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclRaw,
  input  logic     sdaRaw,
  input  winCmd_t  cmd,
  output lineEvt_t evt,
  output logic     winArmed,
  output logic     winLast
);
  localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_CYCLES - 1);

  // Index SYNC_STAGES-1 is the synchronized level, index SYNC_STAGES its previous value
  logic [SYNC_STAGES:0] sclPipe, sdaPipe;
  logic [CNT_W-1:0]     cnt;
  logic                 sclNow, sclOld, sdaNow, sdaOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclRaw};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaRaw};
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sclOld = sclPipe[SYNC_STAGES];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];
  assign sdaOld = sdaPipe[SYNC_STAGES];

  always_comb begin
    evt.sclRise   = sclNow & ~sclOld;
    evt.sclFall   = ~sclNow & sclOld;
    evt.startCond = sclNow & sclOld & ~sdaNow & sdaOld;
    evt.stopCond  = sclNow & sclOld & sdaNow & ~sdaOld;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winArmed <= 1'b0;
      cnt      <= '0;
    end else if (cmd.clear) begin
      winArmed <= 1'b0;
      cnt      <= '0;
    end else if (cmd.arm) begin
      winArmed <= 1'b1;
      cnt      <= '0;
    end else if (winArmed) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign winLast = (cnt == LAST_CNT);
endmodule

// File: rtl/scl_hold_ctl.sv
module scl_hold_ctl
  import scl_hold_pkg::*;
#(
  parameter int BIDX_W    = 4,
  parameter int CHECK_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineEvt_t          evt,
  input  logic [BIDX_W-1:0] bitIdx,
  input  logic              addrByte,
  input  logic              cmdByte,
  input  logic              ackSlot,
  input  logic              swClear,
  input  logic              winArmed,
  input  logic              winLast,
  output winCmd_t           cmd,
  output logic              abortPulse,
  output logic              timeoutSticky
);
  localparam logic [BIDX_W-1:0] KEY_BIT = BIDX_W'(CHECK_BIT);

  logic keyBit, refEdge, expire;

  assign keyBit  = (addrByte | cmdByte) & (bitIdx == KEY_BIT);
  assign refEdge = evt.startCond | (evt.sclRise & (ackSlot | keyBit));
  assign expire  = winArmed & winLast & ~evt.sclFall & ~evt.stopCond & ~refEdge;

  always_comb begin
    cmd.arm   = refEdge;
    cmd.clear = evt.stopCond | evt.sclFall | expire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortPulse    <= 1'b0;
      timeoutSticky <= 1'b0;
    end else begin
      abortPulse <= expire;
      if (abortPulse)   timeoutSticky <= 1'b1;
      else if (swClear) timeoutSticky <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_hold_watchdog.sv
module scl_hold_watchdog
  import scl_hold_pkg::*;
#(
  parameter int WINDOW_CYCLES = 5000,
  parameter int SYNC_STAGES   = 2,
  parameter int BIDX_W        = 4,
  parameter int CHECK_BIT     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRaw,
  input  logic              sdaRaw,
  input  logic [BIDX_W-1:0] bitIdx,
  input  logic              addrByte,
  input  logic              cmdByte,
  input  logic              ackSlot,
  input  logic              swClear,
  output logic              abortPulse,
  output logic              timeoutSticky
);
  lineEvt_t evt;
  winCmd_t  cmd;
  logic     winArmed, winLast;

  scl_hold_dp #(.WINDOW_CYCLES(WINDOW_CYCLES), .SYNC_STAGES(SYNC_STAGES)) dp (
    .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .sdaRaw(sdaRaw),
    .cmd(cmd), .evt(evt), .winArmed(winArmed), .winLast(winLast)
  );

  scl_hold_ctl #(.BIDX_W(BIDX_W), .CHECK_BIT(CHECK_BIT)) ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .bitIdx(bitIdx),
    .addrByte(addrByte), .cmdByte(cmdByte), .ackSlot(ackSlot),
    .swClear(swClear), .winArmed(winArmed), .winLast(winLast),
    .cmd(cmd), .abortPulse(abortPulse), .timeoutSticky(timeoutSticky)
  );
endmodule

// File: rtl/scl_hold_chk.sv
module scl_hold_chk (
  input logic clk,
  input logic rstN,
  input logic sclRaw,
  input logic swClear,
  input logic abortPulse,
  input logic timeoutSticky
);
  // R8
  abort_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> timeoutSticky);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutSticky) |-> $past(swClear));

  // R2
  abort_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> $past(sclRaw, 3));
endmodule

bind scl_hold_watchdog scl_hold_chk chk (
  .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .swClear(swClear),
  .abortPulse(abortPulse), .timeoutSticky(timeoutSticky)
);

// File: tb/scl_hold_watchdog_test.sv
module scl_hold_watchdog_test;
  localparam int W = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclRaw = 1'b1, sdaRaw = 1'b1;
  logic [3:0] bitIdx = '0;
  logic       addrByte = 1'b0, cmdByte = 1'b0, ackSlot = 1'b0, swClear = 1'b0;
  logic       abortPulse, timeoutSticky;

  int checks = 0, failures = 0, abortSeen = 0, base = 0;

  scl_hold_watchdog #(.WINDOW_CYCLES(W)) uut (
    .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .sdaRaw(sdaRaw), .bitIdx(bitIdx),
    .addrByte(addrByte), .cmdByte(cmdByte), .ackSlot(ackSlot), .swClear(swClear),
    .abortPulse(abortPulse), .timeoutSticky(timeoutSticky)
  );

  always #2 clk = ~clk;

  // Behavioural reference model: raw samples queued, newest at the front
  bit sclQ[$], sdaQ[$];
  bit mArmed, mAbort, mSticky;
  int mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ = '{1, 1, 1}; sdaQ = '{1, 1, 1};
      mArmed = 0; mAbort = 0; mSticky = 0; mCnt = 0;
    end else begin
      bit rise, fall, strt, stp, refE, nxt;
      rise = sclQ[1] && !sclQ[2];
      fall = !sclQ[1] && sclQ[2];
      strt = sclQ[1] && sclQ[2] && !sdaQ[1] && sdaQ[2];
      stp  = sclQ[1] && sclQ[2] && sdaQ[1] && !sdaQ[2];
      refE = strt || (rise && (ackSlot || ((addrByte || cmdByte) && bitIdx == 8)));
      nxt = 0;
      if (stp || fall) mArmed = 0;
      else if (refE) begin mArmed = 1; mCnt = 0; end
      else if (mArmed) begin
        if (mCnt == W - 1) begin mArmed = 0; nxt = 1; end
        else mCnt++;
      end
      if (mAbort) mSticky = 1;
      else if (swClear) mSticky = 0;
      mAbort = nxt;
      sclQ.push_front(sclRaw); sdaQ.push_front(sdaRaw);
      sclQ = sclQ[0:2]; sdaQ = sdaQ[0:2];
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    if (abortPulse) abortSeen++;
    check("R7 model abortPulse", int'(abortPulse), int'(mAbort));
    check("R8 model timeoutSticky", int'(timeoutSticky), int'(mSticky));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(input string tag, input int exp);
    cyc(30);
    check(tag, abortSeen - base, exp);
    swClear = 1'b1; cyc(1); swClear = 1'b0; cyc(2);
    base = abortSeen;
  endtask

  task automatic startCond(input int gap);
    sdaRaw = 1'b0; cyc(gap);
    sclRaw = 1'b0; cyc(2);
  endtask

  task automatic goIdle();
    sdaRaw = 1'b1; cyc(2);
    sclRaw = 1'b1; cyc(3);
  endtask

  task automatic runBit(input bit a, input bit c, input bit k, input int idx, input int hold);
    addrByte = a; cmdByte = c; ackSlot = k; bitIdx = 4'(idx); sdaRaw = 1'b0;
    cyc(2); sclRaw = 1'b1; cyc(hold); sclRaw = 1'b0; cyc(2);
    addrByte = 0; cmdByte = 0; ackSlot = 0; bitIdx = '0;
  endtask

  initial begin
    cyc(4); rstN = 1'b1; cyc(1);
    check("R1 reset abortPulse", int'(abortPulse), 0);
    check("R1 reset timeoutSticky", int'(timeoutSticky), 0);
    cyc(40);
    check("R1 idle no abort", abortSeen, 0);

    startCond(5); goIdle(); settle("R2 prompt START", 0);
    startCond(30);
    cyc(5);
    check("R8 sticky after abort", int'(timeoutSticky), 1);
    cyc(50);
    check("R8 sticky held", int'(timeoutSticky), 1);
    check("R2 late START single pulse", abortSeen - base, 1);
    swClear = 1'b1; cyc(1); swClear = 1'b0; cyc(2);
    check("R8 sticky cleared", int'(timeoutSticky), 0);
    base = abortSeen; goIdle();

    startCond(5);
    runBit(1, 0, 0, 8, 10); settle("R3 rw bit in time", 0);
    runBit(1, 0, 0, 8, 30); settle("R3 rw bit late", 1);
    runBit(0, 1, 0, 8, 12); settle("R4 cmd bit8 in time", 0);
    runBit(0, 1, 0, 8, 30); settle("R4 cmd bit8 late", 1);
    runBit(0, 0, 1, 9, 30); settle("R5 ack late", 1);
    runBit(1, 0, 0, 3, 40); runBit(0, 1, 0, 7, 40); runBit(0, 0, 0, 8, 40);
    settle("R6 unchecked bits", 0);
    runBit(0, 0, 1, 9, W);     settle("R7 hold exactly W", 0);
    runBit(0, 0, 1, 9, W + 1); settle("R7 hold W+1", 1);

    // STOP while SCL is high during an armed ACK window
    ackSlot = 1; sdaRaw = 1'b0; cyc(2); sclRaw = 1'b1; cyc(5);
    sdaRaw = 1'b1; cyc(40); ackSlot = 0;
    settle("R9 STOP disarms", 0);

    // Repeated START re-arms during a high ACK clock
    startCond(3);
    ackSlot = 1; sdaRaw = 1'b1; cyc(2); sclRaw = 1'b1; cyc(12);
    sdaRaw = 1'b0; cyc(15); sclRaw = 1'b0; cyc(2); ackSlot = 0;
    settle("R10 re-arm from zero", 0);
    goIdle(); cyc(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule